// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. The integrator, the reference source and the comparator sit outside it. The block drives three analog switch enables: one connects the unknown input to the integrator, one connects the known reference, and one shorts the integrator for auto-zero. All timing comes from a single shared counter that runs on the precision conversion clock.

After a start request the input is integrated for a fixed window of 2^N clocks. The reference is then applied and the same counter, cleared first, measures how long the integrator takes to return to its starting level. The comparator input reports that return. That duration is the conversion result, and it is proportional to the input. If the return does not arrive inside 2^N clocks, the conversion ends early with a full-scale result and an overrange flag. Every conversion finishes with a fixed auto-zero interval, and a new start is accepted only after it. A dead cycle with all switches open separates any two switch phases.

Top module: `dsadc_seq`

## Requirements
- R1: During and after reset the block is idle. `busy_o`, `valid_o`, `ovr_o` and all three switch enables are 0, and `result_o` is 0.
- R2: A `start_i` sampled high while idle raises `busy_o` in the next cycle. In that cycle all switches are still open. `sw_in_o` is then high for exactly 2^N consecutive cycles.
- R3: After one all-open cycle, `sw_ref_o` goes high and the counter starts from 0. The result is the count of the de-integrate cycle in which `cmp_i` is first seen high: 0 if `cmp_i` is high in the first reference cycle.
- R4: If `cmp_i` stays low for all 2^N reference cycles, the result is all ones and `ovr_o` is 1. A trip in the last reference cycle gives all ones with `ovr_o` 0.
- R5: `valid_o` is a one-cycle pulse in the cycle after the de-integrate phase ends, carrying the new `result_o` and `ovr_o`. Both hold their values until the next conversion's pulse.
- R6: After the result, one all-open cycle passes, then `sw_az_o` is high for exactly AZ_CYCLES cycles. Then one more all-open cycle passes, and `busy_o` falls.
- R7: At most one switch enable is high in any cycle. Between two different switch enables there is always at least one cycle with all of them low.
- R8: `start_i` while busy has no effect. The running conversion keeps its timing, produces one result, and no new conversion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Precision conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | High once the integrator is back at its start level |
| sw_in_o | output | 1 | Connect unknown input to integrator |
| sw_ref_o | output | 1 | Connect reference to integrator |
| sw_az_o | output | 1 | Short integrator (auto-zero) |
| result_o | output | N | De-integrate count |
| ovr_o | output | 1 | Last result was overrange |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Conversion or auto-zero in progress |

## Verification
The bench builds the block with N = 4 and AZ_CYCLES = 5. These values keep the integrate window at 16 cycles and make every result code, including both ends of the scale and the overrange path, reachable in a short run. The comparator is modelled as a reference-cycle counter that trips at a chosen target. This lets each case place the trip at an exact count, and lets the bench measure the phase lengths and switch gaps directly at the pins.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP_A = 3'd1,
        ST_INTEG = 3'd2,
        ST_GAP_B = 3'd3,
        ST_DEINT = 3'd4,
        ST_GAP_C = 3'd5,
        ST_AZERO = 3'd6,
        ST_GAP_D = 3'd7
    } seq_state_e;

endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/dsadc_switch_dec.sv
module dsadc_switch_dec
    import dsadc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_i,
    output logic       sw_in_o,
    output logic       sw_ref_o,
    output logic       sw_az_o,
    output logic       busy_o
);

    always_comb begin
        sw_in_o  = (state_i == ST_INTEG);
        sw_ref_o = (state_i == ST_DEINT);
        sw_az_o  = (state_i == ST_AZERO);
        busy_o   = (state_i != ST_IDLE);
    end

    // R7
    one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_in_o, sw_ref_o, sw_az_o}));

    // R7
    in_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_in_o) |-> !(sw_ref_o || sw_az_o));

    // R7
    ref_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_ref_o) |-> !(sw_in_o || sw_az_o));

    // R7
    az_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_az_o) |-> !(sw_in_o || sw_ref_o));

endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int N         = 8,
    parameter int AZ_CYCLES = 32,
    parameter int CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cmp_i,
    input  logic [CW-1:0] cnt_i,
    output logic          cnt_clr_o,
    output logic          cnt_inc_o,
    output seq_state_e    state_o,
    output logic [N-1:0]  result_o,
    output logic          ovr_o,
    output logic          valid_o
);

    localparam logic [CW-1:0] WIN_LAST = CW'((64'd1 << N) - 64'd1);
    localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_CYCLES - 1);

    typedef struct packed {
        seq_state_e   state;
        logic [N-1:0] result;
        logic         ovr;
        logic         valid;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                cnt_clr_o = 1'b1;
                if (start_i)
                    r_d.state = ST_GAP_A;
            end
            ST_GAP_A: begin
                cnt_clr_o = 1'b1;
                r_d.state = ST_INTEG;
            end
            ST_INTEG: begin
                if (cnt_i == WIN_LAST) begin
                    cnt_clr_o = 1'b1;
                    r_d.state = ST_GAP_B;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_GAP_B: begin
                cnt_clr_o = 1'b1;
                r_d.state = ST_DEINT;
            end
            ST_DEINT: begin
                if (cmp_i) begin
                    r_d.result = cnt_i[N-1:0];
                    r_d.ovr    = 1'b0;
                    r_d.valid  = 1'b1;
                    r_d.state  = ST_GAP_C;
                    cnt_clr_o  = 1'b1;
                end else if (cnt_i == WIN_LAST) begin
                    r_d.result = '1;
                    r_d.ovr    = 1'b1;
                    r_d.valid  = 1'b1;
                    r_d.state  = ST_GAP_C;
                    cnt_clr_o  = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_GAP_C: begin
                cnt_clr_o = 1'b1;
                r_d.state = ST_AZERO;
            end
            ST_AZERO: begin
                if (cnt_i == AZ_LAST) begin
                    cnt_clr_o = 1'b1;
                    r_d.state = ST_GAP_D;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_GAP_D: begin
                cnt_clr_o = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                cnt_clr_o = 1'b1;
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.result <= '0;
            r_q.ovr    <= 1'b0;
            r_q.valid  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o  = r_q.state;
    assign result_o = r_q.result;
    assign ovr_o    = r_q.ovr;
    assign valid_o  = r_q.valid;

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(result_o) && $stable(ovr_o)));

    // R4
    ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (result_o == {N{1'b1}}));

    // R8
    integ_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_INTEG && $past(r_q.state) != ST_INTEG)
            |-> ($past(r_q.state) == ST_GAP_A));

    // R3
    deint_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DEINT) |-> (cnt_i <= WIN_LAST));

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
    parameter int N         = 8,
    parameter int AZ_CYCLES = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic         sw_in_o,
    output logic         sw_ref_o,
    output logic         sw_az_o,
    output logic [N-1:0] result_o,
    output logic         ovr_o,
    output logic         valid_o,
    output logic         busy_o
);

    import dsadc_pkg::*;

    localparam int AZW = (AZ_CYCLES > 1) ? $clog2(AZ_CYCLES) : 1;
    localparam int CW  = (N > AZW) ? N : AZW;

    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    seq_state_e    state;

    dsadc_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    dsadc_fsm #(.N(N), .AZ_CYCLES(AZ_CYCLES), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .cnt_i     (cnt),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .state_o   (state),
        .result_o  (result_o),
        .ovr_o     (ovr_o),
        .valid_o   (valid_o)
    );

    dsadc_switch_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .sw_in_o  (sw_in_o),
        .sw_ref_o (sw_ref_o),
        .sw_az_o  (sw_az_o),
        .busy_o   (busy_o)
    );

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !sw_in_o));

endmodule

// File: tb/tb_dsadc_seq.sv
module tb_dsadc_seq;

    localparam int N   = 4;
    localparam int AZ  = 5;
    localparam int WIN = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i = 1'b0;
    logic         sw_in_o, sw_ref_o, sw_az_o, ovr_o, valid_o, busy_o;
    logic [N-1:0] result_o;

    int n_tests = 0;
    int n_fail  = 0;

    int target  = 0;
    int ref_cnt = 0;
    int in_cyc  = 0;
    int az_cyc  = 0;
    int val_cnt = 0;
    int gap_err = 0;
    logic [2:0] prev_sw = 3'b000;

    always #5 clk = ~clk;

    dsadc_seq #(.N(N), .AZ_CYCLES(AZ)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cmp_i    (cmp_i),
        .sw_in_o  (sw_in_o),
        .sw_ref_o (sw_ref_o),
        .sw_az_o  (sw_az_o),
        .result_o (result_o),
        .ovr_o    (ovr_o),
        .valid_o  (valid_o),
        .busy_o   (busy_o)
    );

    // comparator model: trips once reference cycles reach the target
    always @(negedge clk) begin
        if (sw_ref_o) begin
            cmp_i   <= (ref_cnt >= target);
            ref_cnt <= ref_cnt + 1;
        end else begin
            cmp_i   <= 1'b0;
            ref_cnt <= 0;
        end
    end

    // pin monitor
    always @(negedge clk) begin
        logic [2:0] sw;
        sw = {sw_in_o, sw_ref_o, sw_az_o};
        if (rst_n) begin
            if (sw_in_o) in_cyc = in_cyc + 1;
            if (sw_az_o) az_cyc = az_cyc + 1;
            if (valid_o) val_cnt = val_cnt + 1;
            if ($countones(sw) > 1) gap_err = gap_err + 1;
            if (sw != 3'b000 && prev_sw != 3'b000 && sw != prev_sw)
                gap_err = gap_err + 1;
        end
        prev_sw = sw;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic test_reset();
        check(busy_o == 1'b0, "R1 busy", busy_o, 0);
        check({sw_in_o, sw_ref_o, sw_az_o} == 3'b000, "R1 switches",
              {sw_in_o, sw_ref_o, sw_az_o}, 0);
        check(valid_o == 1'b0, "R1 valid", valid_o, 0);
        check(ovr_o == 1'b0, "R1 ovr", ovr_o, 0);
        check(result_o == '0, "R1 result", result_o, 0);
    endtask

    task automatic run_conv(input int tgt, input bit poke);
        int exp_res;
        bit exp_ovr;
        bit seen;
        exp_ovr = (tgt >= WIN);
        exp_res = exp_ovr ? WIN - 1 : tgt;
        target  = tgt;
        tick();
        in_cyc = 0; az_cyc = 0; val_cnt = 0; gap_err = 0;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check(busy_o && !sw_in_o, "R2 busy rises with switches open",
              {busy_o, sw_in_o}, 2);
        tick();
        check(sw_in_o == 1'b1, "R2 input switch on", sw_in_o, 1);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            if (poke && i == 3) start_i = 1'b1;
            if (poke && i == 4) start_i = 1'b0;
            if (valid_o) seen = 1'b1;
            else tick();
        end
        check(seen, "R5 valid seen", seen, 1);
        check(result_o == exp_res[N-1:0], "R3 R4 result", result_o, exp_res);
        check(ovr_o == exp_ovr, "R4 ovr flag", ovr_o, exp_ovr);
        check(in_cyc == WIN, "R2 integrate length", in_cyc, WIN);
        for (int i = 0; i < 200 && busy_o; i++) begin
            if (poke && i == 4) start_i = 1'b1;
            if (poke && i == 5) start_i = 1'b0;
            tick();
        end
        check(az_cyc == AZ, "R6 auto-zero length", az_cyc, AZ);
        check(busy_o == 1'b0, "R6 busy falls", busy_o, 0);
        check(val_cnt == 1, "R5 R8 single valid", val_cnt, 1);
        check(gap_err == 0, "R7 break-before-make", gap_err, 0);
        for (int i = 0; i < 3; i++) tick();
        check(busy_o == 1'b0 && in_cyc == WIN, "R8 no restart after ignored start",
              busy_o, 0);
        check(result_o == exp_res[N-1:0] && ovr_o == exp_ovr, "R5 result held",
              result_o, exp_res);
    endtask

    initial begin
        #2000000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick();
        test_reset();
        tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        run_conv(7, 1'b0);
        run_conv(0, 1'b0);
        run_conv(WIN - 1, 1'b0);
        run_conv(WIN, 1'b0);
        run_conv(3, 1'b1);
        run_conv(WIN + 5, 1'b1);
        run_conv(10, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule